// File: doc/BRIEF.md
# Codec Control Register Bank with Read Overrides

This block holds the codec-side control registers of an AC'97 link as one flat store of 64 sixteen-bit words, addressed by even byte addresses 00h to 7Eh. A slot decoder upstream hands it write requests and read requests. Read requests are answered one clock later on a registered status word, which the slot encoder places in the status slot. A second, combinational read port gives the on-chip processor the raw stored words.

Reads from the link side return the stored word, with a few exceptions. In the two codec-identity registers (28h and 3Ch), bit 14 is taken live from an identity strap pin and bit 15 is forced to 0. Bit 12 of the power-control register (26h) gates the link bit clock and the serial return data to a low level. A warm-reset pulse clears that bit. A write to address 00h starts a register reset: a small sequencer moves from `SEQ_IDLE` to `SEQ_RESTORE` (transition *reset-hit*). It spends exactly one cycle there and loads every register with its default at the end of that cycle. It then returns to `SEQ_IDLE` (transition *restore-done*). In every other case it stays in `SEQ_IDLE` (transition *hold*). A cold reset (`rst_n` low) loads the defaults at once and puts the sequencer in `SEQ_IDLE`.

Top module: `ac97_regbank`

## Requirements
- R1: A write to an even address other than 00h, made while the sequencer is in `SEQ_IDLE`, stores the data. A link read request in cycle n gives the stored word on `stat_rd_data`, with `stat_rd_valid` high, after the clock edge that ends cycle n.
- R2: A link read of 28h or 3Ch returns, in bit 14, the level of `id_strap` at the clock edge that captures the read.
- R3: A link read of 28h or 3Ch returns 0 in bit 15, whatever was written to that bit.
- R4: A link read of 28h or 3Ch returns the stored value in bits 13 to 0.
- R5: While bit 12 of 26h is 1, `link_pd` is 1 and both `link_clk_o` and `link_sdo_o` are 0. While it is 0, those two outputs follow `link_clk_i` and `link_sdo_i`.
- R6: A clock edge with `warm_rst` high clears bit 12 of 26h and leaves the other bits of 26h unchanged. This holds even when the same cycle writes 26h.
- R7: `dsp_rdata` returns, combinationally, the stored word at `dsp_addr` with no override, so the strap level never appears on it.
- R8: A write to an odd address changes no register.
- R9: A read from an odd address returns 0000h, on the link port and on the processor port.
- R10: Cold reset gives 8000h in 02h, 04h and 18h and 0000h in every other register, and clears `stat_rd_data` and `stat_rd_valid`.
- R11: When a write and a link read target the same register in the same cycle, the read returns the old word, and a read in the next cycle returns the new word.
- R12: A write to 00h changes no register in its own cycle. It moves the sequencer to `SEQ_RESTORE` for one cycle. Writes presented in that cycle are dropped, and at its end every register takes its R10 default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| cmd_wr_en | input | 1 | Write request from the slot decoder |
| cmd_wr_addr | input | 7 | Write byte address |
| cmd_wr_data | input | 16 | Write data |
| cmd_rd_en | input | 1 | Link read request |
| cmd_rd_addr | input | 7 | Link read byte address |
| stat_rd_data | output | 16 | Registered read word for the status slot |
| stat_rd_valid | output | 1 | High one cycle after a read request |
| id_strap | input | 1 | Codec identity strap level |
| warm_rst | input | 1 | Warm-reset pulse |
| dsp_addr | input | 7 | Processor-side read byte address |
| dsp_rdata | output | 16 | Processor-side raw stored word |
| link_clk_i | input | 1 | Link bit clock before gating |
| link_sdo_i | input | 1 | Serial return data before gating |
| link_clk_o | output | 1 | Gated link bit clock |
| link_sdo_o | output | 1 | Gated serial return data |
| link_pd | output | 1 | Power-down control, bit 12 of 26h |

## Verification
A wrong stored word shows on `dsp_rdata` as soon as the edge that corrupted it has passed. It shows on `stat_rd_data` one edge after a read request. A sequencer stuck in `SEQ_RESTORE` would keep reloading the defaults, so every write from then on would read back as its default. A power-down bit that is stuck, or that a warm reset fails to clear, shows at once on `link_pd` and on the two gated link outputs. The identity overrides can only be seen through link reads, so these are repeated with both strap levels, and the same registers are read on the processor port for comparison.

// File: rtl/ac97rb_pkg.sv
package ac97rb_pkg;

    localparam int RB_ADDR_W = 7;
    localparam int RB_DATA_W = 16;

    // Word indices (byte address >> 1) of registers with special handling
    localparam int IDX_RESET = 0;    // 00h
    localparam int IDX_PWR   = 19;   // 26h
    localparam int IDX_EXTA  = 20;   // 28h
    localparam int IDX_EXTM  = 30;   // 3Ch

    localparam int PD_BIT      = 12;
    localparam int ID_SA_BIT   = 14;
    localparam int ID_ZERO_BIT = 15;

    typedef enum logic [0:0] {
        SEQ_IDLE    = 1'b0,
        SEQ_RESTORE = 1'b1
    } seq_state_e;

    // Default table: mute on master, headphone and PCM-out volume words
    function automatic logic [RB_DATA_W-1:0] reg_default(int idx);
        case (idx)
            1, 2, 12: reg_default = RB_DATA_W'(16'h8000);
            default:  reg_default = '0;
        endcase
    endfunction

endpackage

// File: rtl/ac97rb_seq.sv
module ac97rb_seq
    import ac97rb_pkg::*;
#(
    parameter int ADDR_W = RB_ADDR_W,
    localparam int IDX_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_commit,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              restore
);

    seq_state_e state_q, state_d;
    logic       even_wr;
    logic       reset_hit;

    assign wr_idx    = wr_addr[ADDR_W-1:1];
    assign even_wr   = wr_en && !wr_addr[0];
    assign reset_hit = even_wr && (wr_idx == IDX_W'(IDX_RESET));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: hold, reset-hit, restore-done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    state_d = reset_hit ? SEQ_RESTORE : SEQ_IDLE;
            SEQ_RESTORE: state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_commit = 1'b0;
        restore   = 1'b0;
        unique case (state_q)
            SEQ_IDLE:    wr_commit = even_wr && !reset_hit;
            SEQ_RESTORE: restore   = 1'b1;
        endcase
    end

    assert_restore_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SEQ_RESTORE |=> state_q == SEQ_IDLE);

    assert_reset_write_no_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reset_hit |-> !wr_commit);

endmodule

// File: rtl/ac97rb_store.sv
module ac97rb_store
    import ac97rb_pkg::*;
#(
    parameter int ADDR_W = RB_ADDR_W,
    parameter int DATA_W = RB_DATA_W,
    localparam int IDX_W  = ADDR_W - 1,
    localparam int NREGS  = 1 << IDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_commit,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         restore,
    input  logic                         warm_rst,
    output logic [NREGS-1:0][DATA_W-1:0] regs
);

    logic [NREGS-1:0][DATA_W-1:0] dflt;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;

        assign dflt[g] = DATA_W'(reg_default(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= DATA_W'(reg_default(g));
            end else if (restore) begin
                q <= DATA_W'(reg_default(g));
            end else begin
                if (wr_commit && (wr_idx == IDX_W'(g))) begin
                    q <= wr_data;
                end
                if ((g == IDX_PWR) && warm_rst) begin
                    q[PD_BIT] <= 1'b0;
                end
            end
        end

        assign regs[g] = q;
    end

    assert_warm_clears_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> !regs[IDX_PWR][PD_BIT]);

    assert_restore_defaults_R12: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> regs == dflt);

endmodule

// File: rtl/ac97rb_readmux.sv
module ac97rb_readmux
    import ac97rb_pkg::*;
#(
    parameter int ADDR_W = RB_ADDR_W,
    parameter int DATA_W = RB_DATA_W,
    localparam int IDX_W  = ADDR_W - 1,
    localparam int NREGS  = 1 << IDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREGS-1:0][DATA_W-1:0] regs,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic                         strap,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_valid,
    input  logic [ADDR_W-1:0]            dsp_addr,
    output logic [DATA_W-1:0]            dsp_rdata
);

    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  dsp_idx;
    logic              id_reg;
    logic [DATA_W-1:0] status_word;

    assign rd_idx  = rd_addr[ADDR_W-1:1];
    assign dsp_idx = dsp_addr[ADDR_W-1:1];
    assign id_reg  = (rd_idx == IDX_W'(IDX_EXTA)) || (rd_idx == IDX_W'(IDX_EXTM));

    always_comb begin
        if (rd_addr[0]) begin
            status_word = '0;
        end else begin
            status_word = regs[rd_idx];
            if (id_reg) begin
                status_word[ID_ZERO_BIT] = 1'b0;
                status_word[ID_SA_BIT]   = strap;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= status_word;
            end
        end
    end

    assign dsp_rdata = dsp_addr[0] ? '0 : regs[dsp_idx];

    assert_rd_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_id_strap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_addr[0] && id_reg |=> rd_data[ID_SA_BIT] == $past(strap));

    assert_id_msb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_addr[0] && id_reg |=> !rd_data[ID_ZERO_BIT]);

    assert_odd_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr[0] |=> rd_data == '0);

endmodule

// File: rtl/ac97_regbank.sv
module ac97_regbank
    import ac97rb_pkg::*;
#(
    parameter int ADDR_W = RB_ADDR_W,
    parameter int DATA_W = RB_DATA_W,
    localparam int IDX_W  = ADDR_W - 1,
    localparam int NREGS  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_en,
    input  logic [ADDR_W-1:0] cmd_wr_addr,
    input  logic [DATA_W-1:0] cmd_wr_data,
    input  logic              cmd_rd_en,
    input  logic [ADDR_W-1:0] cmd_rd_addr,
    output logic [DATA_W-1:0] stat_rd_data,
    output logic              stat_rd_valid,
    input  logic              id_strap,
    input  logic              warm_rst,
    input  logic [ADDR_W-1:0] dsp_addr,
    output logic [DATA_W-1:0] dsp_rdata,
    input  logic              link_clk_i,
    input  logic              link_sdo_i,
    output logic              link_clk_o,
    output logic              link_sdo_o,
    output logic              link_pd
);

    logic                         wr_commit;
    logic [IDX_W-1:0]             wr_idx;
    logic                         restore;
    logic [NREGS-1:0][DATA_W-1:0] regs;

    ac97rb_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cmd_wr_en),
        .wr_addr   (cmd_wr_addr),
        .wr_commit (wr_commit),
        .wr_idx    (wr_idx),
        .restore   (restore)
    );

    ac97rb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .wr_idx    (wr_idx),
        .wr_data   (cmd_wr_data),
        .restore   (restore),
        .warm_rst  (warm_rst),
        .regs      (regs)
    );

    ac97rb_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_readmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .regs      (regs),
        .rd_en     (cmd_rd_en),
        .rd_addr   (cmd_rd_addr),
        .strap     (id_strap),
        .rd_data   (stat_rd_data),
        .rd_valid  (stat_rd_valid),
        .dsp_addr  (dsp_addr),
        .dsp_rdata (dsp_rdata)
    );

    // Power-down gating of the link outputs
    assign link_pd    = regs[IDX_PWR][PD_BIT];
    assign link_clk_o = link_clk_i & ~link_pd;
    assign link_sdo_o = link_sdo_i & ~link_pd;

    assert_link_silenced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        regs[IDX_PWR][PD_BIT] |-> (!link_clk_o && !link_sdo_o));

    assert_odd_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_en && cmd_wr_addr[0] && !warm_rst && !restore |=> $stable(regs));

endmodule

// File: tb/test_ac97_regbank.sv
module test_ac97_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [6:0]  cmd_wr_addr = '0;
    logic [15:0] cmd_wr_data = '0;
    logic        cmd_rd_en = 1'b0;
    logic [6:0]  cmd_rd_addr = '0;
    logic [15:0] stat_rd_data;
    logic        stat_rd_valid;
    logic        id_strap = 1'b0;
    logic        warm_rst = 1'b0;
    logic [6:0]  dsp_addr = '0;
    logic [15:0] dsp_rdata;
    logic        link_clk_i = 1'b1;
    logic        link_sdo_i = 1'b1;
    logic        link_clk_o;
    logic        link_sdo_o;
    logic        link_pd;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    ac97_regbank i_ac97_regbank (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_en(cmd_wr_en), .cmd_wr_addr(cmd_wr_addr), .cmd_wr_data(cmd_wr_data),
        .cmd_rd_en(cmd_rd_en), .cmd_rd_addr(cmd_rd_addr),
        .stat_rd_data(stat_rd_data), .stat_rd_valid(stat_rd_valid),
        .id_strap(id_strap), .warm_rst(warm_rst),
        .dsp_addr(dsp_addr), .dsp_rdata(dsp_rdata),
        .link_clk_i(link_clk_i), .link_sdo_i(link_sdo_i),
        .link_clk_o(link_clk_o), .link_sdo_o(link_sdo_o), .link_pd(link_pd)
    );

    // Vector: {req[3:0], op[1:0], addr[6:0], data[15:0], strap, expect[15:0]}
    // op 0 = write, 1 = link read (checked after one edge), 2 = processor read
    localparam int NV = 14;
    localparam logic [45:0] VEC [NV] = '{
        {4'd1,  2'd0, 7'h02, 16'h1234, 1'b0, 16'h0000},  // R1 write
        {4'd1,  2'd1, 7'h02, 16'h0000, 1'b0, 16'h1234},  // R1 read back
        {4'd4,  2'd0, 7'h28, 16'hFFFF, 1'b0, 16'h0000},
        {4'd3,  2'd1, 7'h28, 16'h0000, 1'b0, 16'h3FFF},  // R3 R4 strap low
        {4'd2,  2'd1, 7'h28, 16'h0000, 1'b1, 16'h7FFF},  // R2 strap high
        {4'd7,  2'd2, 7'h28, 16'h0000, 1'b1, 16'hFFFF},  // R7 raw word
        {4'd4,  2'd0, 7'h3C, 16'h8001, 1'b0, 16'h0000},
        {4'd2,  2'd1, 7'h3C, 16'h0000, 1'b1, 16'h4001},  // R2 R3
        {4'd4,  2'd1, 7'h3C, 16'h0000, 1'b0, 16'h0001},  // R4
        {4'd1,  2'd0, 7'h7E, 16'hA5A5, 1'b0, 16'h0000},
        {4'd1,  2'd1, 7'h7E, 16'h0000, 1'b0, 16'hA5A5},  // R1 top address
        {4'd8,  2'd0, 7'h03, 16'h5555, 1'b0, 16'h0000},  // R8 odd write
        {4'd8,  2'd1, 7'h02, 16'h0000, 1'b0, 16'h1234},  // R8 neighbour intact
        {4'd9,  2'd1, 7'h03, 16'h0000, 1'b0, 16'h0000}   // R9 odd read
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        cmd_wr_en = 1'b1; cmd_wr_addr = a; cmd_wr_data = d;
        tick;
        cmd_wr_en = 1'b0;
    endtask

    task automatic dsp_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
        dsp_addr = a;
        #1;
        chk(req, dsp_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [45:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 valid", {15'b0, stat_rd_valid}, 16'h0000);
        chk("R10 data", stat_rd_data, 16'h0000);
        rst_n = 1'b1;
        tick;
        dsp_chk("R10 02h", 7'h02, 16'h8000);
        dsp_chk("R10 18h", 7'h18, 16'h8000);
        dsp_chk("R10 26h", 7'h26, 16'h0000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            id_strap = v[16];
            case (v[41:40])
                2'd0: wr(v[39:33], v[32:17]);
                2'd1: begin
                    cmd_rd_en = 1'b1; cmd_rd_addr = v[39:33];
                    tick;
                    cmd_rd_en = 1'b0;
                    chk($sformatf("R%0d vec %0d", v[45:42], i), stat_rd_data, v[15:0]);
                    chk($sformatf("R1 valid vec %0d", i), {15'b0, stat_rd_valid}, 16'h0001);
                end
                default: dsp_chk($sformatf("R%0d vec %0d", v[45:42], i), v[39:33], v[15:0]);
            endcase
        end
        id_strap = 1'b0;

        // R9 odd processor read
        dsp_chk("R9 dsp odd", 7'h03, 16'h0000);

        // R5 power-down gating
        chk("R5 open clk", {15'b0, link_clk_o}, 16'h0001);
        wr(7'h26, 16'h10FF);
        chk("R5 pd", {15'b0, link_pd}, 16'h0001);
        chk("R5 clk low", {15'b0, link_clk_o}, 16'h0000);
        chk("R5 sdo low", {15'b0, link_sdo_o}, 16'h0000);

        // R6 warm reset with simultaneous write of 26h
        warm_rst = 1'b1;
        wr(7'h26, 16'h1F0F);
        warm_rst = 1'b0;
        dsp_chk("R6 26h", 7'h26, 16'h0F0F);
        chk("R6 clk open", {15'b0, link_clk_o}, 16'h0001);
        chk("R6 sdo open", {15'b0, link_sdo_o}, 16'h0001);

        // R11 same-cycle write and read
        wr(7'h10, 16'h1111);
        cmd_wr_en = 1'b1; cmd_wr_addr = 7'h10; cmd_wr_data = 16'h2222;
        cmd_rd_en = 1'b1; cmd_rd_addr = 7'h10;
        tick;
        cmd_wr_en = 1'b0;
        chk("R11 old", stat_rd_data, 16'h1111);
        tick;
        cmd_rd_en = 1'b0;
        chk("R11 new", stat_rd_data, 16'h2222);

        // R12 register reset via write to 00h
        wr(7'h00, 16'hFFFF);
        dsp_chk("R12 unchanged", 7'h10, 16'h2222);
        dsp_chk("R12 00h", 7'h00, 16'h0000);
        wr(7'h12, 16'h7777);
        dsp_chk("R12 restored", 7'h10, 16'h0000);
        dsp_chk("R12 dropped", 7'h12, 16'h0000);
        dsp_chk("R12 default", 7'h02, 16'h8000);
        dsp_chk("R12 id", 7'h28, 16'h0000);
        wr(7'h12, 16'h7777);
        dsp_chk("R12 back idle", 7'h12, 16'h7777);

        // R10 cold reset mid-run
        wr(7'h7E, 16'h0BAD);
        wr(7'h04, 16'h0001);
        rst_n = 1'b0;
        #3;
        dsp_chk("R10 cold 7Eh", 7'h7E, 16'h0000);
        dsp_chk("R10 cold 04h", 7'h04, 16'h8000);
        chk("R10 cold valid", {15'b0, stat_rd_valid}, 16'h0000);
        rst_n = 1'b1;
        tick;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule